// File: doc/BRIEF.md
# Serial Transmit Path with Queue and Busy Tracking

This block turns bytes into asynchronous serial frames on a single output line. A producer hands bytes over on a valid/ready write port. They are held in a small queue, and a shift-register serializer drains that queue. Each frame has a low start bit, 5 to 8 data bits sent least significant first, an optional parity bit and one or two high stop bits. The serializer captures the frame format from the line-control inputs at the moment it takes a byte from the queue. When the queue still holds data as a frame ends, the next frame follows with no idle time on the line.

Bit timing comes from outside the block. A one-cycle `bit_tick` pulse advances the serializer, and every bit lasts `TICKS_PER_BIT` of these pulses. The block has no baud generator of its own. The `busy` output rises as soon as the queue holds a byte. It stays high while a frame is on the line and while a break is driven. It falls only after the last stop bit of the last queued byte has finished. Back-pressure follows the usual rule: a byte is accepted on a cycle where `wr_valid` and `wr_ready` are both high, and `wr_ready` is low while the queue is full. If a producer asserts `wr_valid` while the queue is full, that byte is discarded and a sticky overflow flag is set.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `fifo_empty` is 1, `fifo_full` is 0, `wr_ready` is 1 and `overflow` is 0.
- R2: A byte is accepted when `wr_valid` and `wr_ready` are both high. The queue holds `FIFO_DEPTH` bytes. `fifo_full` rises and `wr_ready` falls once that many bytes are waiting.
- R3: A byte offered while the queue is full is discarded and sets `overflow`. The flag then stays at 1 until reset, and the queued contents are unchanged.
- R4: A frame is one start bit at 0, then `cfg_len_code`+5 data bits (code 0 gives 5 bits, code 3 gives 8 bits), least significant bit first.
- R5: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_odd` at 0, the count of ones in the data bits plus the parity bit is even. With `cfg_par_odd` at 1, that count is odd.
- R6: The frame ends with one stop bit at 1, or two stop bits when `cfg_stop2` is 1. Every bit lasts `TICKS_PER_BIT` pulses of `bit_tick`.
- R7: While `tx_en` is 1 and the queue is not empty, each frame begins right after the previous frame's last stop bit, and bytes go out in the order they were accepted.
- R8: `busy` is 1 in the cycle after a byte is accepted. It stays 1 until the queue is empty and the last stop bit has ended, then it returns to 0 with `txd` at 1.
- R9: While `cfg_break` is 1, `txd` is 0 and `busy` is 1, and no byte is taken from the queue. When `cfg_break` returns to 0, the line goes back to 1 or resumes sending.
- R10: While `tx_en` is 0, no new frame starts and `txd` stays 1. A frame already on the line runs to its end, and `busy` stays 1 while bytes remain queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Allows new frames to start |
| bit_tick | input | 1 | One-cycle timing pulse, TICKS_PER_BIT per bit |
| wr_valid | input | 1 | Producer offers a byte |
| wr_data | input | 8 | Byte offered |
| wr_ready | output | 1 | Queue can accept a byte |
| cfg_len_code | input | 2 | Data length code, length = code + 5 |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_odd | input | 1 | Selects odd (1) or even (0) parity |
| cfg_stop2 | input | 1 | Selects two stop bits |
| cfg_break | input | 1 | Forces the line low |
| txd | output | 1 | Serial output line, idle high |
| busy | output | 1 | Queue non-empty, frame in flight or break active |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| overflow | output | 1 | Sticky: a byte was offered while full |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and `TICKS_PER_BIT` = 4, and pulses `bit_tick` on every other cycle, so one bit lasts 8 clock cycles. With bits that short, a full sweep over all 24 combinations of data length, parity mode and stop count fits easily in the run, and each frame is decoded by sampling at mid-bit. The depth of 4 lets a few writes reach the full and overflow conditions, and a four-frame back-to-back drain can be checked for order.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W    = 8;
  localparam int MIN_LEN   = 5;
  localparam int FRAME_MAX = 1 + DATA_W + 1 + 2;
  localparam int FIW       = $clog2(FRAME_MAX);
  localparam int FLW       = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } line_cfg_t;

  // Whole frame, bit 0 first on the line; unused upper bits are idle ones.
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                       input line_cfg_t c);
    logic [FRAME_MAX-1:0] f;
    logic p;
    int n;
    n = int'(c.len_code) + MIN_LEN;
    f = '1;
    f[0] = 1'b0;
    p = c.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        f[FIW'(i + 1)] = d[i];
        p = p ^ d[i];
      end
    end
    if (c.par_en) f[FIW'(n + 1)] = p;
    return f;
  endfunction

  function automatic logic [FLW-1:0] frame_len(input line_cfg_t c);
    return FLW'(2 + MIN_LEN + int'(c.len_code) + int'(c.par_en) + int'(c.stop2));
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic         full,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (in_valid && full) ovf <= 1'b1;
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready) |=> full);
  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  line_cfg_t         cfg,
  input  logic              brk,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              active,
  output logic              txd
);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  logic [TW-1:0]        tick_cnt;
  logic [FLW-1:0]       bits_left;
  logic [FRAME_MAX-1:0] shreg;
  logic                 bit_done, last_bit, may_start;

  assign bit_done  = active && bit_tick && (tick_cnt == TW'(TICKS_PER_BIT - 1));
  assign last_bit  = bit_done && (bits_left == FLW'(1));
  assign may_start = tx_en && !brk && src_valid && (!active || last_bit);
  assign src_ready = may_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      tick_cnt  <= '0;
      bits_left <= '0;
      shreg     <= '1;
    end else if (may_start) begin
      active    <= 1'b1;
      tick_cnt  <= '0;
      shreg     <= build_frame(src_data, cfg);
      bits_left <= frame_len(cfg);
    end else if (bit_done) begin
      tick_cnt <= '0;
      if (last_bit) begin
        active <= 1'b0;
        shreg  <= '1;
      end else begin
        shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
        bits_left <= bits_left - 1'b1;
      end
    end else if (active && bit_tick) begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  assign txd = brk ? 1'b0 : (active ? shreg[0] : 1'b1);

  assert_no_start_in_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !active) |=> !active);
  assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !active) |=> !active);
  assert_start_bit_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> !shreg[0]);

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH    = 4,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic [1:0]        cfg_len_code,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              cfg_break,
  output logic              txd,
  output logic              busy,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              overflow
);
  line_cfg_t         cfg;
  logic              q_valid, q_ready, active;
  logic [DATA_W-1:0] q_data;

  assign cfg = '{len_code: cfg_len_code, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, stop2: cfg_stop2};

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_valid), .in_data(wr_data), .in_ready(wr_ready),
    .out_valid(q_valid), .out_data(q_data), .out_ready(q_ready),
    .full(fifo_full), .empty(fifo_empty), .ovf(overflow)
  );

  uart_tx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
    .cfg(cfg), .brk(cfg_break),
    .src_valid(q_valid), .src_data(q_data), .src_ready(q_ready),
    .active(active), .txd(txd)
  );

  assign busy = !fifo_empty || active || cfg_break;

  assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> busy);

endmodule

// File: tb/uart_tx_path_tb.sv
module uart_tx_path_tb;
  localparam int DEPTH = 4;
  localparam int TPB   = 4;
  localparam int BITC  = TPB * 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, bit_tick = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len_code = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0, cfg_break = 1'b0;
  logic wr_ready, txd, busy, fifo_full, fifo_empty, overflow;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  uart_tx_path #(.FIFO_DEPTH(DEPTH), .TICKS_PER_BIT(TPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .cfg_len_code(cfg_len_code), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_break(cfg_break),
    .txd(txd), .busy(busy), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .overflow(overflow)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      bit_tick <= ~bit_tick;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Decodes one frame with the current configuration, sampling at mid-bit.
  task automatic recv(output logic [7:0] d, output logic p,
                      output logic s_ok, output logic st_ok);
    int guard = 0;
    int n = int'(cfg_len_code) + 5;
    @(negedge clk);
    while (txd && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    repeat (BITC / 2 - 1) @(negedge clk);
    st_ok = !txd;
    d = '0;
    for (int i = 0; i < n; i++) begin
      repeat (BITC) @(negedge clk);
      d[i] = txd;
    end
    p = 1'b0;
    if (cfg_par_en) begin
      repeat (BITC) @(negedge clk);
      p = txd;
    end
    s_ok = 1'b1;
    for (int i = 0; i < (cfg_stop2 ? 2 : 1); i++) begin
      repeat (BITC) @(negedge clk);
      s_ok = s_ok & txd;
    end
  endtask

  task automatic check_frame(input logic [7:0] sent, input bit last);
    logic [7:0] d, mask;
    logic p, s_ok, st_ok;
    int ones;
    recv(d, p, s_ok, st_ok);
    mask = 8'((1 << (int'(cfg_len_code) + 5)) - 1);
    ones = $countones(sent & mask);
    chk("R4 start bit low", int'(st_ok), 1);
    chk("R4 data bits", int'(d), int'(sent & mask));
    if (cfg_par_en) chk("R5 parity bit", int'(p), cfg_par_odd ? (1 - ones % 2) : ones % 2);
    chk("R6 stop bits high", int'(s_ok), 1);
    if (last) begin
      chk("R8 busy during last stop", int'(busy), 1);
      repeat (BITC) @(negedge clk);
      chk("R8 busy low after frame", int'(busy), 0);
      chk("R8 line idle after frame", int'(txd), 1);
    end
  endtask

  initial begin
    logic [7:0] vals [4];
    repeat (3) @(negedge clk);
    chk("R1 txd", int'(txd), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 empty", int'(fifo_empty), 1);
    chk("R1 full", int'(fifo_full), 0);
    chk("R1 ready", int'(wr_ready), 1);
    chk("R1 overflow", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tx_en = 1'b1;

    // Full sweep over length, parity mode and stop count.
    for (int len = 0; len < 4; len++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int st = 0; st < 2; st++) begin
          logic [7:0] d;
          d = 8'h5A ^ 8'((len * 12 + pm * 4 + st) * 29);
          cfg_len_code = 2'(len);
          cfg_par_en   = (pm != 0);
          cfg_par_odd  = (pm == 2);
          cfg_stop2    = st[0];
          push(d);
          chk("R8 busy after write", int'(busy), 1);
          check_frame(d, 1'b1);
        end
      end
    end

    // Fill while disabled, overflow, then back-to-back drain.
    cfg_len_code = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    tx_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      vals[i] = 8'h11 * 8'(i + 3);
      push(vals[i]);
    end
    chk("R2 full after depth writes", int'(fifo_full), 1);
    chk("R2 ready low when full", int'(wr_ready), 0);
    chk("R3 no overflow yet", int'(overflow), 0);
    push(8'hEE);
    chk("R3 overflow set", int'(overflow), 1);
    repeat (40) @(negedge clk);
    chk("R10 line stays idle disabled", int'(txd), 1);
    chk("R10 busy with queued data", int'(busy), 1);
    chk("R3 overflow sticky", int'(overflow), 1);
    tx_en = 1'b1;
    for (int i = 0; i < 4; i++) check_frame(vals[i], i == 3);
    chk("R7 queue drained, dropped byte absent", int'(fifo_empty), 1);

    // Break: line low, busy high, queue untouched until release.
    cfg_break = 1'b1;
    @(negedge clk);
    chk("R9 break drives low", int'(txd), 0);
    chk("R9 busy during break", int'(busy), 1);
    push(8'hC3);
    repeat (60) @(negedge clk);
    chk("R9 no pop during break", int'(fifo_empty), 0);
    chk("R9 line still low", int'(txd), 0);
    cfg_break = 1'b0;
    check_frame(8'hC3, 1'b1);
    cfg_break = 1'b1;
    @(negedge clk);
    cfg_break = 1'b0;
    @(negedge clk);
    chk("R9 release returns high", int'(txd), 1);
    chk("R9 busy clears on release", int'(busy), 0);

    // Disable during a frame: it finishes, the next waits.
    push(8'h96);
    push(8'h3C);
    tx_en = 1'b0;
    check_frame(8'h96, 1'b0);
    repeat (50) @(negedge clk);
    chk("R10 next frame held", int'(txd), 1);
    chk("R10 busy while queued", int'(busy), 1);
    chk("R10 byte still queued", int'(fifo_empty), 0);
    tx_en = 1'b1;
    check_frame(8'h3C, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule